// File: doc/BRIEF.md
# Probabilistic Neighbour Refresh Injector

This block sits beside the command path of a DRAM controller and watches row-close (precharge) events. Each close is treated as a random trial. When the trial succeeds, the block queues a request to open and close one row that is physically adjacent to the row just closed. That extra activation restores the charge in a row that repeated openings of its neighbour may have disturbed. The block keeps no history per row and no activation counters. Its only state is a pseudo-random generator, a short request queue and a count of dropped requests.

The success probability is set by a 16-bit threshold, and the chance per close is about threshold/65536. A threshold near 328 gives roughly one refresh per two hundred closes, and a larger threshold gives stronger protection at the cost of more command bandwidth. Queued requests go to the command scheduler over a valid/ready handshake. A seed input makes the random sequence repeatable.

Top module: `nbr_refresh_inj`

## Requirements
- R1: While `rst_n` is low, the generator is loaded from `seed`, with a seed of 0 replaced by 1. `req_valid` and `drop_count` read 0 during reset.
- R2: The generator is a 16-bit register. On every clock edge after reset it shifts left by one, and its new bit 0 is bit15 xor bit13 xor bit12 xor bit10.
- R3: A close (`close_valid` high at a clock edge) triggers a refresh exactly when the generator value at that edge is below `thresh`, so a threshold of 0 never triggers.
- R4: The target row is adjacent to the closed row. If generator bit 0 is 1 the target is the row plus one, and if it is 0 the target is the row minus one. Row 0 always targets row 1, and row ROWS-1 always targets row ROWS-2.
- R5: A request carries the bank of its close unchanged.
- R6: Triggered requests enter a 4-entry first-in first-out queue and show on `req_valid` from the cycle after the trigger. An entry leaves on a clock edge where `req_valid` and `req_ready` are both high. While a request waits without `req_ready`, `req_bank` and `req_row` stay stable.
- R7: A trigger that finds the queue holding 4 entries is dropped, and `drop_count` then increments, saturating at its maximum. A removal on the same edge does not make room for it.
- R8: Over many consecutive closes, the fraction of closes that trigger matches `thresh`/65536 within a small tolerance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed | input | 16 | Generator seed, loaded during reset |
| thresh | input | 16 | Trigger threshold, compared as probability thresh/65536 |
| close_valid | input | 1 | A row close happens this cycle |
| close_bank | input | BANK_W | Bank of the closed row |
| close_row | input | ROW_W | Index of the closed row |
| req_valid | output | 1 | A refresh request is waiting |
| req_ready | input | 1 | The scheduler takes the request |
| req_bank | output | BANK_W | Bank of the request |
| req_row | output | ROW_W | Row to refresh |
| drop_count | output | DROP_W | Saturating count of triggers lost to a full queue |

## Verification
On every cycle, the assertions check that the generator never reaches zero and that each enqueued target lies exactly one row from its close. They also check that a waiting request holds steady, that no request appears without a qualifying close, that the queue occupancy never exceeds its depth, and that each drop advances the counter. The exact sequence of targets, the choice of neighbour at the two edge rows, reproducibility from a given seed and the long-run trigger rate can only be shown by the bench. It runs a cycle-exact reference model across boundary, overflow, zero-threshold, mixed-traffic and rate scenarios.

// File: rtl/nbr_refresh_inj.sv
module nbr_refresh_inj #(
  parameter int BANK_W = 3,
  parameter int ROWS   = 32768,
  parameter int DEPTH  = 4,
  parameter int DROP_W = 16,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       seed,
  input  logic [15:0]       thresh,
  input  logic              close_valid,
  input  logic [BANK_W-1:0] close_bank,
  input  logic [ROW_W-1:0]  close_row,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [BANK_W-1:0] req_bank,
  output logic [ROW_W-1:0]  req_row,
  output logic [DROP_W-1:0] drop_count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [15:0] lfsr;
  logic [BANK_W-1:0] bank_q [DEPTH];
  logic [ROW_W-1:0]  row_q  [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;

  wire fb    = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];
  wire hit   = close_valid && (lfsr < thresh);
  wire full  = (count == CNT_W'(DEPTH));
  wire push  = hit && !full;
  wire pop   = req_valid && req_ready;
  wire go_up = (close_row == '0) || (lfsr[0] && close_row != ROW_LAST);
  wire [ROW_W-1:0] tgt = go_up ? close_row + ROW_W'(1) : close_row - ROW_W'(1);

  assign req_valid = (count != '0);
  assign req_bank  = bank_q[rd_ptr];
  assign req_row   = row_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= (seed == 16'd0) ? 16'd1 : seed;
    else        lfsr <= {lfsr[14:0], fb};
  end

  always_ff @(posedge clk) begin
    if (push) begin
      bank_q[wr_ptr] <= close_bank;
      row_q[wr_ptr]  <= tgt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      drop_count <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PTR_W'(1);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      if (hit && full && drop_count != '1) drop_count <= drop_count + DROP_W'(1);
    end
  end

  a_r2_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'd0);

  a_r4_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (tgt == close_row + ROW_W'(1)) || (tgt + ROW_W'(1) == close_row));

  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!close_valid || thresh == 16'd0) |=> !$rose(req_valid));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid && $stable(req_bank) && $stable(req_row));

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  a_r7_drop_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && full && drop_count != '1) |=> drop_count == $past(drop_count) + DROP_W'(1));
endmodule

// File: tb/test_nbr_refresh_inj.sv
`timescale 1ns/1ps
module test_nbr_refresh_inj;
  localparam int BANK_W = 3;
  localparam int ROWS   = 32768;
  localparam int ROW_W  = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] seed = 16'hACE1;
  logic [15:0] thresh = 16'd0;
  logic close_valid = 1'b0;
  logic [BANK_W-1:0] close_bank = '0;
  logic [ROW_W-1:0] close_row = '0;
  logic req_ready = 1'b0;
  logic req_valid;
  logic [BANK_W-1:0] req_bank;
  logic [ROW_W-1:0] req_row;
  logic [15:0] drop_count;

  nbr_refresh_inj #(.BANK_W(BANK_W), .ROWS(ROWS), .DEPTH(4), .DROP_W(16)) i_nbr_refresh_inj (
    .clk(clk), .rst_n(rst_n), .seed(seed), .thresh(thresh),
    .close_valid(close_valid), .close_bank(close_bank), .close_row(close_row),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
    .req_row(req_row), .drop_count(drop_count));

  always #2 clk = ~clk;

  int vectors = 0;
  int fails = 0;
  logic [15:0] m_lfsr;
  int m_drop;
  int qb[$];
  int qr[$];
  int qc[$];
  int handshakes;
  int edge_hs;

  task automatic check(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic compare();
    check("R6 req_valid", int'(req_valid), int'(qb.size() > 0));
    if (qb.size() > 0 && req_valid) begin
      check("R5 req_bank", int'(req_bank), qb[0]);
      check("R2/R4 req_row", int'(req_row), qr[0]);
    end
    check("R7 drop_count", int'(drop_count), m_drop);
  endtask

  task automatic step(input bit cv, input int b, input int r, input bit rdy);
    bit pop, hit, full;
    int tgt;
    close_valid = cv; close_bank = BANK_W'(b); close_row = ROW_W'(r); req_ready = rdy;
    pop  = (qb.size() > 0) && rdy;
    full = (qb.size() == 4);
    hit  = cv && (m_lfsr < thresh);
    if (pop) begin
      handshakes++;
      if (qc[0] == 0 || qc[0] == ROWS - 1) edge_hs++;
      // R4: every delivered target sits exactly one row from its close
      check("R4 distance", (qr[0] > qc[0]) ? qr[0] - qc[0] : qc[0] - qr[0], 1);
      void'(qb.pop_front()); void'(qr.pop_front()); void'(qc.pop_front());
    end
    if (hit) begin
      if (full) begin
        if (m_drop < 65535) m_drop++;
      end else begin
        if (r == 0) tgt = 1;
        else if (r == ROWS - 1) tgt = r - 1;
        else tgt = m_lfsr[0] ? r + 1 : r - 1;
        qb.push_back(b); qr.push_back(tgt); qc.push_back(r);
      end
    end
    // R2: shift left, feedback from taps 15,13,12,10
    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset(input logic [15:0] s);
    @(negedge clk);
    rst_n = 1'b0; seed = s; close_valid = 1'b0; req_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 req_valid in reset", int'(req_valid), 0);
    check("R1 drop_count in reset", int'(drop_count), 0);
    rst_n = 1'b1;
    m_lfsr = (s == 16'd0) ? 16'd1 : s;
    m_drop = 0;
    qb.delete(); qr.delete(); qc.delete();
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int hs0, d0;
    do_reset(16'hACE1);

    // R4 edge rows
    thresh = 16'hFFFF;
    edge_hs = 0;
    for (int i = 0; i < 8; i++) begin
      step(1'b1, i % 8, 0, 1'b1);
      step(1'b1, (i + 3) % 8, ROWS - 1, 1'b1);
    end
    repeat (6) step(1'b0, 0, 0, 1'b1);
    check("R4 edge rows delivered", int'(edge_hs >= 12), 1);

    // R7 overflow with a stalled scheduler
    for (int i = 0; i < 12; i++) step(1'b1, i % 8, 100 + i, 1'b0);
    check("R7 drops recorded", int'(drop_count != 0), 1);
    step(1'b1, 5, 500, 1'b1);
    repeat (8) step(1'b0, 0, 0, 1'b1);

    // R3 zero threshold
    thresh = 16'd0;
    hs0 = handshakes;
    for (int i = 0; i < 300; i++) step(1'b1, $urandom % 8, $urandom % ROWS, $urandom % 2);
    check("R3 no request at threshold 0", handshakes - hs0, 0);

    // mixed traffic
    thresh = 16'd20000;
    for (int i = 0; i < 3000; i++)
      step(($urandom % 3) != 0, $urandom % 8, $urandom % ROWS, ($urandom % 4) != 0);
    repeat (8) step(1'b0, 0, 0, 1'b1);

    // R1 zero seed, R2 sequence from substitute seed
    do_reset(16'd0);
    thresh = 16'hFFFF;
    for (int i = 0; i < 60; i++) step(1'b1, $urandom % 8, $urandom % ROWS, 1'b1);
    repeat (8) step(1'b0, 0, 0, 1'b1);

    // R8 rate near the default probability
    thresh = 16'd328;
    hs0 = handshakes; d0 = m_drop;
    for (int i = 0; i < 60000; i++) step(1'b1, i % 8, 1 + (i % (ROWS - 2)), 1'b1);
    repeat (8) step(1'b0, 0, 0, 1'b1);
    check("R8 rate at 328/65536", int'((handshakes - hs0 + m_drop - d0) inside {[240:360]}), 1);

    thresh = 16'd6554;
    hs0 = handshakes; d0 = m_drop;
    for (int i = 0; i < 20000; i++) step(1'b1, i % 8, $urandom % ROWS, 1'b1);
    repeat (8) step(1'b0, 0, 0, 1'b1);
    check("R8 rate at 6554/65536", int'((handshakes - hs0 + m_drop - d0) inside {[1800:2200]}), 1);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule